// File: doc/BRIEF.md
# PS/2 Host Command Transmitter

This block lets a host send one command byte to a PS/2 keyboard. The clock and data lines are open-collector, so the block never drives a high level. For each line it gives a pull-low enable, and it reads the level back through a synchronizer. A start strobe with a byte first holds the clock line low for a timed inhibit window. The block then pulls data low to request a send and releases the clock. From then on the device generates the clock. The block puts each frame bit on the data line after a falling clock edge, so the device can latch it on the next rising edge.

The frame is the byte LSB first, then an odd parity bit, then a stop bit of 1. The host sends the stop bit by releasing the data line. After the stop bit the block looks for the device acknowledge and reports the result with a single-cycle `done` or `err` pulse. If the device stops clocking, a timeout releases both lines and reports an error.

Top module: `ps2_cmd_tx`

## Requirements
- R1: Out of reset and whenever `busy` is low, both `clkPullLow` and `datPullLow` are 0, and `done` and `err` are never high in the same cycle.
- R2: A `start` seen while idle raises `busy` and `clkPullLow` on the next clock edge, with `datPullLow` still 0. The clock line stays pulled low for at least CLK_MHZ*INHIBIT_US system cycles (at most two cycles more).
- R3: When the inhibit ends, `datPullLow` goes to 1 while the clock is still held low. It stays 1 in the cycle where `clkPullLow` returns to 0. This is the start bit, which is 0.
- R4: After the k-th falling edge of the device clock (k = 1..10), the block puts frame bit k on the data line, where 1 means released. Bits 1..8 are the byte LSB first, bit 9 is odd parity (the ones in byte plus parity make an odd count), and bit 10 is the stop bit, 1. Each bit is stable when the following rising edge comes.
- R5: If the data line is low at the 11th falling edge (the acknowledge), `done` pulses for one cycle, `busy` drops in that same cycle, and `err` stays 0.
- R6: If the data line is high at the 11th falling edge, `err` pulses for one cycle instead of `done`.
- R7: After the clock release, if CLK_MHZ*TIMEOUT_US cycles pass with no falling clock edge (counted from the release or from the last falling edge), the transfer aborts. `err` pulses and both lines are released.
- R8: A `start` that arrives while `busy` is high is ignored: the byte on the wire and the single completion pulse belong to the first request.
- R9: A send request takes priority over traffic from the device. A `start` that arrives while the device is pulling the clock low is accepted all the same, and `clkPullLow` is 1 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to send `txByte` |
| txByte | input | DATA_BITS | Command byte, captured with `start` |
| ps2ClkIn | input | 1 | Level of the PS/2 clock line (asynchronous) |
| ps2DatIn | input | 1 | Level of the PS/2 data line (asynchronous) |
| clkPullLow | output | 1 | 1 pulls the clock line low, 0 releases it |
| datPullLow | output | 1 | 1 pulls the data line low, 0 releases it |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse: frame sent and acknowledged |
| err | output | 1 | One-cycle pulse: no acknowledge, or timeout |

## Verification
Some of the hardest cases to reach through the ports depend on the device clock running against the host. One is a `start` that arrives while the device is already clocking. Another is a device that stops partway through a frame, which has to hit the inter-edge timeout rather than the first-edge one. The bench includes a device model that can run a fake reception before the request, can stop after any number of pulses, and can withhold the acknowledge. A second thread fires a competing `start` during the inhibit window, so the ignore rule is tested against a transfer already in progress.

// File: rtl/ps2_tx_pkg.sv
package ps2_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_INHIBIT = 2'd1,
    ST_REQ     = 2'd2,
    ST_SHIFT   = 2'd3
  } txState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture byte, build frame, present start bit
    logic shift;     // present next frame bit, advance bit count
    logic timerClr;  // restart the shared cycle timer
  } txCmd_t;

  // conditions from datapath to control
  typedef struct packed {
    logic clkFall;      // synchronized falling edge of the device clock
    logic datLevel;     // synchronized data line level
    logic inhibitDone;  // inhibit window has elapsed
    logic timeoutHit;   // no device activity for the timeout window
    logic frameSent;    // all frame bits have been presented
  } txStat_t;

endpackage

// File: rtl/ps2_tx_datapath.sv
module ps2_tx_datapath
  import ps2_tx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int CLK_MHZ     = 200,
  parameter int INHIBIT_US  = 100,
  parameter int TIMEOUT_US  = 15000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  txCmd_t               cmd,
  input  logic [DATA_BITS-1:0] txByte,
  input  logic                 ps2ClkIn,
  input  logic                 ps2DatIn,
  output txStat_t              stat,
  output logic                 datDrive
);

  localparam int FRAME_BITS  = DATA_BITS + 2;           // data, parity, stop
  localparam int CW          = $clog2(FRAME_BITS + 1);
  localparam int INHIBIT_CYC = CLK_MHZ * INHIBIT_US;
  localparam int TIMEOUT_CYC = CLK_MHZ * TIMEOUT_US;
  localparam int MAX_CYC     = (INHIBIT_CYC > TIMEOUT_CYC) ? INHIBIT_CYC : TIMEOUT_CYC;
  localparam int TW          = $clog2(MAX_CYC + 1);

  logic [SYNC_STAGES-1:0] clkSync, datSync;
  logic                   clkPrev;
  logic [TW-1:0]          timer;
  logic [FRAME_BITS-1:0]  frameReg;
  logic [CW-1:0]          bitCnt;

  // line synchronizers, idle-high reset value
  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkSync <= '1;
      datSync <= '1;
      clkPrev <= 1'b1;
    end else begin
      clkSync <= {clkSync[SYNC_STAGES-2:0], ps2ClkIn};
      datSync <= {datSync[SYNC_STAGES-2:0], ps2DatIn};
      clkPrev <= clkSync[SYNC_STAGES-1];
    end
  end

  // shared saturating timer for inhibit and timeout windows
  always_ff @(posedge clk) begin
    if (!rstN || cmd.timerClr) begin
      timer <= '0;
    end else if (timer != TW'(MAX_CYC)) begin
      timer <= timer + 1'b1;
    end
  end

  // frame shifter: bit 0 of frameReg is the next bit to present
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameReg <= '1;
      bitCnt   <= '0;
      datDrive <= 1'b0;
    end else if (cmd.load) begin
      frameReg <= {1'b1, ~^txByte, txByte};
      bitCnt   <= '0;
      datDrive <= 1'b1;                    // start bit is a low level
    end else if (cmd.shift) begin
      datDrive <= ~frameReg[0];
      frameReg <= {1'b1, frameReg[FRAME_BITS-1:1]};
      bitCnt   <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    stat.clkFall     = clkPrev & ~clkSync[SYNC_STAGES-1];
    stat.datLevel    = datSync[SYNC_STAGES-1];
    stat.inhibitDone = (timer == TW'(INHIBIT_CYC - 1));
    stat.timeoutHit  = (timer >= TW'(TIMEOUT_CYC - 1));
    stat.frameSent   = (bitCnt == CW'(FRAME_BITS));
  end

endmodule

// File: rtl/ps2_tx_ctrl.sv
module ps2_tx_ctrl
  import ps2_tx_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  txStat_t  stat,
  output txCmd_t   cmd,
  output txState_t state,
  output logic     done,
  output logic     err
);

  txState_t nextState;
  logic     finishOk, finishBad;

  always_comb begin
    nextState = state;
    cmd       = '0;
    finishOk  = 1'b0;
    finishBad = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          cmd.load     = 1'b1;
          cmd.timerClr = 1'b1;
          nextState    = ST_INHIBIT;
        end
      end
      ST_INHIBIT: begin
        if (stat.inhibitDone) nextState = ST_REQ;
      end
      ST_REQ: begin
        cmd.timerClr = 1'b1;
        nextState    = ST_SHIFT;
      end
      ST_SHIFT: begin
        if (stat.clkFall) begin
          cmd.timerClr = 1'b1;
          if (!stat.frameSent) begin
            cmd.shift = 1'b1;
          end else begin
            nextState = ST_IDLE;
            finishOk  = ~stat.datLevel;
            finishBad = stat.datLevel;
          end
        end else if (stat.timeoutHit) begin
          nextState = ST_IDLE;
          finishBad = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      state <= nextState;
      done  <= finishOk;
      err   <= finishBad;
    end
  end

endmodule

// File: rtl/ps2_cmd_tx.sv
module ps2_cmd_tx
  import ps2_tx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int CLK_MHZ     = 200,
  parameter int INHIBIT_US  = 100,
  parameter int TIMEOUT_US  = 15000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [DATA_BITS-1:0] txByte,
  input  logic                 ps2ClkIn,
  input  logic                 ps2DatIn,
  output logic                 clkPullLow,
  output logic                 datPullLow,
  output logic                 busy,
  output logic                 done,
  output logic                 err
);

  txCmd_t   cmd;
  txStat_t  stat;
  txState_t state;
  logic     datDrive;

  ps2_tx_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .stat  (stat),
    .cmd   (cmd),
    .state (state),
    .done  (done),
    .err   (err)
  );

  ps2_tx_datapath #(
    .DATA_BITS  (DATA_BITS),
    .CLK_MHZ    (CLK_MHZ),
    .INHIBIT_US (INHIBIT_US),
    .TIMEOUT_US (TIMEOUT_US),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .txByte   (txByte),
    .ps2ClkIn (ps2ClkIn),
    .ps2DatIn (ps2DatIn),
    .stat     (stat),
    .datDrive (datDrive)
  );

  assign busy       = (state != ST_IDLE);
  assign clkPullLow = (state == ST_INHIBIT) || (state == ST_REQ);
  assign datPullLow = datDrive && ((state == ST_REQ) || (state == ST_SHIFT));

endmodule

// File: rtl/ps2_cmd_tx_chk.sv
module ps2_cmd_tx_chk #(
  parameter int INHIBIT_CYC = 20000
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic done,
  input logic err,
  input logic clkPullLow,
  input logic datPullLow
);

  int lowRun;

  always_ff @(posedge clk) begin
    if (!rstN)                       lowRun <= 0;
    else if (!clkPullLow)            lowRun <= 0;
    else if (lowRun < INHIBIT_CYC+8) lowRun <= lowRun + 1;
  end

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!clkPullLow && !datPullLow));

  // R1
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && err));

  // R5
  finish_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done || err) |-> !busy);

  // R2
  start_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && clkPullLow && !datPullLow));

  // R2
  inhibit_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkPullLow) |-> (lowRun >= INHIBIT_CYC));

  // R3
  rts_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkPullLow) |-> datPullLow);

endmodule

bind ps2_cmd_tx ps2_cmd_tx_chk #(.INHIBIT_CYC(CLK_MHZ * INHIBIT_US)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .clkPullLow (clkPullLow),
  .datPullLow (datPullLow)
);

// File: tb/ps2_cmd_tx_bench.sv
`timescale 1ns/1ps
module ps2_cmd_tx_bench;

  localparam int CLK_MHZ = 200;
  localparam int INH_US  = 2;
  localparam int TO_US   = 20;
  localparam int INH_CYC = CLK_MHZ * INH_US;
  localparam int TO_CYC  = CLK_MHZ * TO_US;
  localparam int HALF    = 40;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [7:0] txByte = 8'h00;
  logic       devClkLow = 1'b0;
  logic       devDatLow = 1'b0;
  logic       clkLine, datLine;
  logic       clkPullLow, datPullLow, busy, done, err;

  assign clkLine = ~(clkPullLow | devClkLow);
  assign datLine = ~(datPullLow | devDatLow);

  ps2_cmd_tx #(
    .DATA_BITS(8), .CLK_MHZ(CLK_MHZ), .INHIBIT_US(INH_US),
    .TIMEOUT_US(TO_US), .SYNC_STAGES(2)
  ) u_ps2_cmd_tx (
    .clk(clk), .rstN(rstN), .start(start), .txByte(txByte),
    .ps2ClkIn(clkLine), .ps2DatIn(datLine),
    .clkPullLow(clkPullLow), .datPullLow(datPullLow),
    .busy(busy), .done(done), .err(err)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int lowRun = 0;
  int lastLowRun = 0;
  int doneCnt = 0;
  int errCnt = 0;

  always @(posedge clk) begin
    if (clkPullLow) lowRun <= lowRun + 1;
    else begin
      if (lowRun != 0) lastLowRun <= lowRun;
      lowRun <= 0;
    end
    if (done) doneCnt <= doneCnt + 1;
    if (err)  errCnt  <= errCnt + 1;
  end

  function automatic logic oddParity(input logic [7:0] b);
    return ~^b;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // device model: waits for request-to-send, then gives up to 11 clock pulses
  task automatic devRun(input bit ack, input int pulses,
                        output logic [9:0] got, output bit rtsOk);
    int guard = 0;
    got = '0;
    while (!(busy && clkLine && !datLine) && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    rtsOk = (guard < 20000);
    repeat (HALF) @(negedge clk);
    for (int p = 1; p <= pulses && p <= 11; p++) begin
      devClkLow = 1'b1;
      repeat (HALF) @(negedge clk);
      devClkLow = 1'b0;
      if (p <= 10) got[p-1] = datLine;   // latched at rising edge
      if (p == 10) devDatLow = ack;
      repeat (HALF) @(negedge clk);
    end
    devDatLow = 1'b0;
  endtask

  // mode 0: plain, 1: competing start during inhibit, 2: device clocking before request
  task automatic sendByte(input logic [7:0] b, input bit ack, input int mode);
    logic [9:0] got;
    bit rtsOk;
    int dBase = doneCnt;
    int eBase = errCnt;
    if (mode == 2) begin
      devClkLow = 1'b1; repeat (HALF) @(negedge clk);
      devClkLow = 1'b0; repeat (HALF) @(negedge clk);
      devClkLow = 1'b1; repeat (10) @(negedge clk);
    end
    start = 1'b1; txByte = b;
    @(negedge clk);
    start = 1'b0;
    if (mode == 2) begin
      check(clkPullLow && busy, "R9", "request taken while device clocks", clkPullLow, 1);
      repeat (HALF) @(negedge clk);
      devClkLow = 1'b0;
    end else begin
      check(busy && clkPullLow && !datPullLow, "R2", "inhibit begins, data free",
            {busy, clkPullLow, datPullLow}, 3'b110);
    end
    fork
      devRun(ack, 11, got, rtsOk);
      begin
        if (mode == 1) begin
          repeat (50) @(negedge clk);
          start = 1'b1; txByte = ~b;
          @(negedge clk);
          start = 1'b0; txByte = b;
        end
      end
    join
    repeat (6) @(negedge clk);
    check(rtsOk, "R3", "request-to-send seen", rtsOk, 1);
    check(lastLowRun >= INH_CYC && lastLowRun <= INH_CYC + 2, "R2", "clock low cycles",
          lastLowRun, INH_CYC + 1);
    check(got[7:0] == b, "R4", "data bits LSB first", got[7:0], b);
    check(got[8] == oddParity(b), "R4", "odd parity", got[8], oddParity(b));
    check(got[9] == 1'b1, "R4", "stop bit", got[9], 1);
    check(doneCnt - dBase == (ack ? 1 : 0), ack ? "R5" : "R6", "done pulses",
          doneCnt - dBase, ack ? 1 : 0);
    check(errCnt - eBase == (ack ? 0 : 1), ack ? "R5" : "R6", "err pulses",
          errCnt - eBase, ack ? 0 : 1);
    check(!busy && !clkPullLow && !datPullLow, "R1", "idle after transfer",
          {busy, clkPullLow, datPullLow}, 0);
    if (mode == 1) begin
      repeat (20) @(negedge clk);
      check(!busy && !clkPullLow, "R8", "ignored start did not start a transfer", busy, 0);
    end
  endtask

  // device clocks a few pulses (possibly none) and then goes silent
  task automatic stallCase(input logic [7:0] b, input int pulses);
    logic [9:0] got;
    bit rtsOk;
    int eBase = errCnt;
    int dBase = doneCnt;
    start = 1'b1; txByte = b;
    @(negedge clk);
    start = 1'b0;
    devRun(1'b0, pulses, got, rtsOk);
    repeat (TO_CYC - 200) @(negedge clk);
    check(busy, "R7", "no early abort", busy, 1);
    repeat (400) @(negedge clk);
    check(errCnt - eBase == 1 && doneCnt == dBase, "R7", "timeout error pulse",
          errCnt - eBase, 1);
    check(!busy && !clkPullLow && !datPullLow, "R7", "lines released after timeout",
          {busy, clkPullLow, datPullLow}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h00c0ffee));
    repeat (5) @(negedge clk);
    check(!busy && !clkPullLow && !datPullLow && !done && !err, "R1", "reset state",
          {busy, clkPullLow, datPullLow, done, err}, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    sendByte(8'h00, 1'b1, 0);
    sendByte(8'hFF, 1'b1, 0);
    sendByte(8'hED, 1'b1, 1);   // R8 competing start
    sendByte(8'h01, 1'b0, 0);   // R6 missing acknowledge
    sendByte(8'h5A, 1'b1, 2);   // R9 device clocking when request arrives
    for (int i = 0; i < 6; i++) begin
      logic [7:0] rb = 8'($urandom);
      bit rack = ($urandom % 4) != 0;
      sendByte(rb, rack, 0);
    end
    stallCase(8'hA5, 0);        // R7 device never clocks
    stallCase(8'h3C, 4);        // R7 device stops mid-frame

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule